// File: doc/BRIEF.md
# Key-protected watchdog timer

A watchdog timer that sits on a simple word-addressed register bus and runs from the peripheral clock. Software programs a mode word (enable, which outputs to drive, and how long each output pulse lasts) and a control word (prescale selection and the high part of the restart value). Once enabled, a down-counter is decremented once per prescaled tick. Software must keep rewriting a magic value to the restart word to reload the counter. If it fails to do so and the counter reaches zero, the block sets a sticky zero flag. It can also emit a reset pulse, an interrupt pulse, or both, each of a programmed length.

Writes to the mode and control words are protected: each carries a key field inside the written word, and a write whose key is wrong changes nothing. The restart word only acts on one exact 16-bit value. The reload value is the programmed high field followed by a run of one bits (`LOW_W` of them, twelve by default). The prescale step is `PRE_STEP` bits per selection code, three by default. A small bench build shrinks both parameters to keep run times short.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the mode word (word 0, byte offset 0x00) reads 0x1C2, the control word (offset 0x04) reads 0x3C, the status word (offset 0x0C) reads 0, and both pulse outputs are low.
- R2: A write to offset 0x00 updates the mode fields only when bits 23:12 equal 0xABC; otherwise the readback is unchanged. The mode fields are: run enable in bit 0, reset-output enable in bit 1, interrupt enable in bit 2, reset length code in bits 6:4, and interrupt length code in bits 8:7. All other bits read as zero.
- R3: A write to offset 0x04 updates the prescale code (bits 1:0) and the restart high field N (bits 13:2) only when bits 25:14 equal 0x248; otherwise the readback is unchanged. All other bits read as zero.
- R4: A write to offset 0x08 with bits 15:0 equal to 0x1999 reloads the counter with {N, LOW_W ones}, restarts the prescaler, and clears the zero flag. Any other value written there leaves the countdown timing untouched.
- R5: While enabled, the counter falls by one every 2^(PRE_STEP*(code+1)) clock cycles, so with the default parameters the four codes divide by 8, 64, 512 and 4096. From a reload to reaching zero takes reload value × divide cycles.
- R6: On reaching zero, bit 0 of the status word at 0x0C is set and stays set. The counter then holds at zero and raises no further pulses until it is reloaded.
- R7: A reset pulse is issued at zero only when both the run enable and the reset-output enable are set. It is high for 2^(code+1) cycles, so 2 to 256 cycles.
- R8: An interrupt pulse is issued at zero only when both the run enable and the interrupt enable are set. It is high for 2^(code+2) cycles, so 4 to 32 cycles.
- R9: With the run enable clear, the counter does not advance and no zero event occurs. A mode write that turns the run enable from 0 to 1 reloads the counter and restarts the prescaler.
- R10: A keyed restart that lands in the same cycle as the step to zero wins. No pulse is issued, the flag stays clear, and a full new countdown begins.
- R11: Offset 0x08 always reads zero, and writes to offset 0x0C have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Byte address; bits 3:2 select the word |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data including key fields |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| wd_rst_o | output | 1 | Reset request pulse |
| wd_irq_o | output | 1 | Interrupt request pulse |

## Verification
Two functions can meet in the same cycle: the keyed restart and the counter's final step to zero. The bench counts cycles from the enabling write and places the restart write so that its clock edge is exactly the one on which the count would reach zero. It then requires both outputs to stay low and the zero flag to stay clear. It also requires a complete fresh countdown measured from that edge. The same placement with a wrong restart value must let the zero event fire on time, which shows that only the key decides the outcome.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [11:0] MODE_KEY = 12'hABC;
  localparam logic [11:0] CTRL_KEY = 12'h248;
  localparam logic [15:0] KICK_KEY = 16'h1999;

  localparam logic [1:0] WORD_MODE = 2'd0;
  localparam logic [1:0] WORD_CTRL = 2'd1;
  localparam logic [1:0] WORD_KICK = 2'd2;
  localparam logic [1:0] WORD_STAT = 2'd3;

  typedef struct packed {
    logic [1:0] irq_code;
    logic [2:0] rst_code;
    logic       irq_on;
    logic       rst_on;
    logic       run;
  } mode_t;

  typedef struct packed {
    logic [11:0] reload_hi;
    logic [1:0]  div_sel;
  } ctrl_t;

  localparam mode_t MODE_INIT = '{irq_code: 2'b11, rst_code: 3'b100,
                                  irq_on: 1'b0, rst_on: 1'b1, run: 1'b0};
  localparam ctrl_t CTRL_INIT = '{reload_hi: 12'h00F, div_sel: 2'b00};

  // reset pulse: 2 << code cycles (2..256)
  function automatic logic [8:0] rst_pulse_len(input logic [2:0] code);
    return 9'd2 << code;
  endfunction

  // interrupt pulse: 4 << code cycles (4..32)
  function automatic logic [8:0] irq_pulse_len(input logic [1:0] code);
    return 9'd4 << code;
  endfunction

  function automatic mode_t word_to_mode(input logic [31:0] w);
    mode_t m;
    m.run      = w[0];
    m.rst_on   = w[1];
    m.irq_on   = w[2];
    m.rst_code = w[6:4];
    m.irq_code = w[8:7];
    return m;
  endfunction

  function automatic logic [31:0] mode_to_word(input mode_t m);
    logic [31:0] w;
    w      = '0;
    w[0]   = m.run;
    w[1]   = m.rst_on;
    w[2]   = m.irq_on;
    w[6:4] = m.rst_code;
    w[8:7] = m.irq_code;
    return w;
  endfunction

  function automatic ctrl_t word_to_ctrl(input logic [31:0] w);
    ctrl_t c;
    c.div_sel   = w[1:0];
    c.reload_hi = w[13:2];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
    logic [31:0] w;
    w       = '0;
    w[1:0]  = c.div_sel;
    w[13:2] = c.reload_hi;
    return w;
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic        status,
  output mode_t       mode_q,
  output ctrl_t       ctrl_q,
  output logic        kick_evt,
  output logic        arm_evt,
  output logic [31:0] bus_rdata
);

  logic [1:0] word;
  logic       mode_wr;
  logic       ctrl_wr;

  assign word     = bus_addr[3:2];
  assign mode_wr  = bus_wr && (word == WORD_MODE) && (bus_wdata[23:12] == MODE_KEY);
  assign ctrl_wr  = bus_wr && (word == WORD_CTRL) && (bus_wdata[25:14] == CTRL_KEY);
  assign kick_evt = bus_wr && (word == WORD_KICK) && (bus_wdata[15:0] == KICK_KEY);
  assign arm_evt  = mode_wr && bus_wdata[0] && !mode_q.run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_INIT;
      ctrl_q <= CTRL_INIT;
    end else begin
      if (mode_wr) mode_q <= word_to_mode(bus_wdata);
      if (ctrl_wr) ctrl_q <= word_to_ctrl(bus_wdata);
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (word)
      WORD_MODE: bus_rdata = mode_to_word(mode_q);
      WORD_CTRL: bus_rdata = ctrl_to_word(ctrl_q);
      WORD_KICK: bus_rdata = '0;
      WORD_STAT: bus_rdata = {31'd0, status};
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter  int STEP  = 3,
  localparam int PRE_W = STEP * 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clear,
  input  logic [1:0] sel,
  output logic       tick
);

  logic [PRE_W-1:0] lim_tab [4];
  logic [PRE_W-1:0] pre_q;

  for (genvar g = 0; g < 4; g++) begin : g_lim
    localparam int SH = STEP * (g + 1);
    assign lim_tab[g] = PRE_W'((64'd1 << SH) - 64'd1);
  end

  assign tick = run && (pre_q == lim_tab[sel]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (clear)  pre_q <= '0;
    else if (run)    pre_q <= tick ? '0 : pre_q + PRE_W'(1);
  end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter  int HI_W  = 12,
  parameter  int LOW_W = 12,
  localparam int CNT_W = HI_W + LOW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             load,
  input  logic             kick,
  input  logic [HI_W-1:0]  reload_hi,
  output logic [CNT_W-1:0] cnt_q,
  output logic             zero_evt,
  output logic             status_q
);

  function automatic logic [CNT_W-1:0] reload_of(input logic [HI_W-1:0] hi);
    return {hi, {LOW_W{1'b1}}};
  endfunction

  assign zero_evt = run && tick && !load && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= reload_of(reload_hi);
    end else if (run && tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        status_q <= 1'b0;
    else if (kick)     status_q <= 1'b0;
    else if (zero_evt) status_q <= 1'b1;
  end

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [LEN_W-1:0] len,
  output logic             active
);

  logic [LEN_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (fire)           left_q <= len;
    else if (left_q != '0)   left_q <= left_q - LEN_W'(1);
  end

  assign active = (left_q != '0);

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter  int LOW_W    = 12,
  parameter  int PRE_STEP = 3,
  localparam int HI_W     = 12,
  localparam int CNT_W    = HI_W + LOW_W,
  localparam int LEN_W    = 9,
  localparam int N_CH     = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wd_rst_o,
  output logic        wd_irq_o
);

  mode_t            mode_q;
  ctrl_t            ctrl_q;
  logic             kick_evt;
  logic             arm_evt;
  logic             load_evt;
  logic             tick;
  logic             zero_evt;
  logic             status_q;
  logic [CNT_W-1:0] cnt_q;

  // named views for the checker
  logic run_w, rst_on_w, irq_on_w;
  assign run_w    = mode_q.run;
  assign rst_on_w = mode_q.rst_on;
  assign irq_on_w = mode_q.irq_on;
  assign load_evt = kick_evt | arm_evt;

  wdog_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .status    (status_q),
    .mode_q    (mode_q),
    .ctrl_q    (ctrl_q),
    .kick_evt  (kick_evt),
    .arm_evt   (arm_evt),
    .bus_rdata (bus_rdata)
  );

  wdog_prescale #(.STEP(PRE_STEP)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_w),
    .clear (load_evt),
    .sel   (ctrl_q.div_sel),
    .tick  (tick)
  );

  wdog_counter #(.HI_W(HI_W), .LOW_W(LOW_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_w),
    .tick      (tick),
    .load      (load_evt),
    .kick      (kick_evt),
    .reload_hi (ctrl_q.reload_hi),
    .cnt_q     (cnt_q),
    .zero_evt  (zero_evt),
    .status_q  (status_q)
  );

  logic [N_CH-1:0]            ch_fire;
  logic [N_CH-1:0][LEN_W-1:0] ch_len;
  logic [N_CH-1:0]            ch_active;

  assign ch_fire[0] = zero_evt && run_w && rst_on_w;
  assign ch_fire[1] = zero_evt && run_w && irq_on_w;
  assign ch_len[0]  = rst_pulse_len(mode_q.rst_code);
  assign ch_len[1]  = irq_pulse_len(mode_q.irq_code);

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    wdog_pulse #(.LEN_W(LEN_W)) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (ch_fire[ch]),
      .len    (ch_len[ch]),
      .active (ch_active[ch])
    );
  end

  assign wd_rst_o = ch_active[0];
  assign wd_irq_o = ch_active[1];

endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             rst_on,
  input logic             irq_on,
  input logic             zero_evt,
  input logic             kick_evt,
  input logic             load_evt,
  input logic [CNT_W-1:0] cnt,
  input logic             status,
  input logic             wd_rst_o,
  input logic             wd_irq_o
);

  AST_RST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_rst_o) |-> $past(zero_evt && run && rst_on)); // R7

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_irq_o) |-> $past(zero_evt && run && irq_on)); // R8

  AST_FLAG_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> status); // R6

  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kick_evt |=> !status); // R4

  AST_HOLD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !load_evt) |=> (cnt == '0)); // R6

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_evt) |=> $stable(cnt)); // R9

  AST_KICK_BEATS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    kick_evt |-> !zero_evt); // R10

endmodule

bind wdog_keyed wdog_keyed_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run_w),
  .rst_on   (rst_on_w),
  .irq_on   (irq_on_w),
  .zero_evt (zero_evt),
  .kick_evt (kick_evt),
  .load_evt (load_evt),
  .cnt      (cnt_q),
  .status   (status_q),
  .wd_rst_o (wd_rst_o),
  .wd_irq_o (wd_irq_o)
);

// File: tb/tb_wdog_keyed.sv
module tb_wdog_keyed;

  localparam int LW = 4;
  localparam int PS = 1;
  localparam int CYCLE_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire         wd_rst_o;
  wire         wd_irq_o;

  wdog_keyed #(.LOW_W(LW), .PRE_STEP(PS)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wd_rst_o(wd_rst_o), .wd_irq_o(wd_irq_o)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int vectors = 0;
  int errors  = 0;
  int t0      = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic int reload_val(input int n);
    return n * (1 << LW) + (1 << LW) - 1;
  endfunction

  function automatic int div_of(input int sel);
    return 1 << (PS * (sel + 1));
  endfunction

  function automatic logic [31:0] mode_w(input int en, input int rs, input int iq,
                                         input int rl, input int il, input int key);
    return (32'(key) << 12) | (32'(il) << 7) | (32'(rl) << 4) |
           (32'(iq) << 2) | (32'(rs) << 1) | 32'(en);
  endfunction

  function automatic logic [31:0] ctrl_w(input int n, input int sel, input int key);
    return (32'(key) << 14) | (32'(n) << 2) | 32'(sel);
  endfunction

  function automatic logic [31:0] mode_rb(input int en, input int rs, input int iq,
                                          input int rl, input int il);
    return mode_w(en, rs, iq, rl, il, 0);
  endfunction

  // waits for the first pulse; delta counts cycles from t0
  task automatic watch(input int limit, output int delta, output int rlen, output int ilen);
    delta = -1; rlen = 0; ilen = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (wd_rst_o || wd_irq_o) begin
        delta = cyc - t0;
        break;
      end
    end
    if (delta >= 0) begin
      for (int k = 0; k < 300; k++) begin
        if (wd_rst_o) rlen++;
        if (wd_irq_o) ilen++;
        @(negedge clk);
      end
    end
  endtask

  task automatic run_case(input string tag, input int n, input int sel, input int rs,
                          input int iq, input int rl, input int il);
    int d, a, b, span;
    span = reload_val(n) * div_of(sel);
    wr(4'h0, mode_w(0, rs, iq, rl, il, 'hABC));
    wr(4'h4, ctrl_w(n, sel, 'h248));
    wr(4'h0, mode_w(1, rs, iq, rl, il, 'hABC));
    t0 = cyc;
    watch(span + 20, d, a, b);
    check({tag, " delay"}, d, (rs != 0 || iq != 0) ? span : -1);
    check({tag, " rst_len"}, a, rs != 0 ? (2 << rl) : 0);
    check({tag, " irq_len"}, b, iq != 0 ? (4 << il) : 0);
  endtask

  initial begin
    logic [31:0] r;
    int d, a, b, span;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'h0, r); check("R1 mode reset", r, 32'h1C2);
    rd(4'h4, r); check("R1 ctrl reset", r, 32'h3C);
    rd(4'hC, r); check("R1 status reset", r, 0);
    check("R1 outputs low", {wd_rst_o, wd_irq_o}, 0);

    // R2 mode sweep, keyed and unkeyed, reserved bits read zero
    for (int rl = 0; rl < 8; rl++) begin
      for (int il = 0; il < 4; il++) begin
        wr(4'h0, mode_w(0, rl & 1, il & 1, rl, il, 'hABC) | 32'h0E08);
        rd(4'h0, r); check("R2 keyed mode", r, mode_rb(0, rl & 1, il & 1, rl, il));
        wr(4'h0, mode_w(0, ~rl & 1, ~il & 1, 7 - rl, 3 - il, 'hABD));
        rd(4'h0, r); check("R2 bad key mode", r, mode_rb(0, rl & 1, il & 1, rl, il));
      end
    end

    // R3 control sweep
    for (int sel = 0; sel < 4; sel++) begin
      for (int j = 0; j < 4; j++) begin
        int n;
        n = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 'hA5 : 'hFFF;
        wr(4'h4, ctrl_w(n, sel, 'h248) | 32'hFC00_0000);
        rd(4'h4, r); check("R3 keyed ctrl", r, (n << 2) | sel);
        wr(4'h4, ctrl_w(n ^ 'h3C, sel ^ 1, 'h249));
        rd(4'h4, r); check("R3 bad key ctrl", r, (n << 2) | sel);
      end
    end

    // R11 restart word reads zero, status write ignored
    wr(4'h8, 32'h0000_1999);
    rd(4'h8, r); check("R11 restart reads zero", r, 0);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, r); check("R11 status write ignored", r, 0);

    // R5 prescale sweep with R7/R8 pulse lengths
    for (int sel = 0; sel < 4; sel++) begin
      run_case("R5 sel", 0, sel, 1, 1, sel, sel);
      run_case("R5 n1", 1, sel, 1, 1, 7 - sel, 3 - sel);
    end
    for (int rl = 0; rl < 8; rl++) run_case("R7 length", 0, 0, 1, 0, rl, 0);
    for (int il = 0; il < 4; il++) run_case("R8 length", 0, 0, 0, 1, 0, il);
    run_case("R7 R8 both off", 0, 0, 0, 0, 2, 2);

    // R6 flag set, no refire, then R4 keyed restart clears and recounts
    run_case("R6 base", 0, 1, 1, 1, 0, 0);
    rd(4'hC, r); check("R6 status set", r, 1);
    t0 = cyc;
    watch(400, d, a, b); check("R6 no refire", d, -1);
    rd(4'hC, r); check("R6 status sticky", r, 1);
    wr(4'h8, 32'h0000_1999);
    t0 = cyc;
    rd(4'hC, r); check("R4 restart clears flag", r, 0);
    watch(200, d, a, b); check("R4 recount", d, reload_val(0) * div_of(1));

    // R4 wrong restart value keeps timing
    wr(4'h0, mode_w(0, 1, 1, 0, 0, 'hABC));
    wr(4'h0, mode_w(1, 1, 1, 0, 0, 'hABC));
    t0 = cyc;
    repeat (5) @(negedge clk);
    wr(4'h8, 32'h0000_1998);
    watch(200, d, a, b); check("R4 wrong value ignored", d, reload_val(0) * div_of(1));

    // R4 keyed restart mid-count restarts the whole countdown
    wr(4'h0, mode_w(0, 1, 1, 0, 0, 'hABC));
    wr(4'h0, mode_w(1, 1, 1, 0, 0, 'hABC));
    repeat (20) @(negedge clk);
    wr(4'h8, 32'h0000_1999);
    t0 = cyc;
    watch(200, d, a, b); check("R4 mid restart", d, reload_val(0) * div_of(1));

    // R9 disabled: no event; re-enable reloads
    wr(4'h4, ctrl_w(0, 0, 'h248));
    wr(4'h0, mode_w(0, 1, 1, 0, 0, 'hABC));
    wr(4'h8, 32'h0000_1999);
    t0 = cyc;
    watch(120, d, a, b); check("R9 frozen no event", d, -1);
    rd(4'hC, r); check("R9 frozen flag clear", r, 0);
    wr(4'h0, mode_w(1, 1, 1, 0, 0, 'hABC));
    repeat (12) @(negedge clk);
    wr(4'h0, mode_w(0, 1, 1, 0, 0, 'hABC));
    repeat (60) @(negedge clk);
    wr(4'h0, mode_w(1, 1, 1, 0, 0, 'hABC));
    t0 = cyc;
    watch(200, d, a, b); check("R9 enable reloads", d, reload_val(0) * div_of(0));

    // R10 keyed restart lands on the zero edge
    span = reload_val(0) * div_of(0);
    wr(4'h0, mode_w(0, 1, 1, 0, 0, 'hABC));
    wr(4'h8, 32'h0000_1999);
    wr(4'h0, mode_w(1, 1, 1, 0, 0, 'hABC));
    repeat (span - 2) @(negedge clk);
    wr(4'h8, 32'h0000_1999);
    t0 = cyc;
    check("R10 no pulse on collision", {wd_rst_o, wd_irq_o}, 0);
    rd(4'hC, r); check("R10 flag clear", r, 0);
    watch(200, d, a, b);
    check("R10 fresh countdown", d, span);
    check("R10 rst len", a, 2);
    check("R10 irq len", b, 4);

    // R4 same placement with a wrong value: zero fires on time
    wr(4'h0, mode_w(0, 1, 1, 0, 0, 'hABC));
    wr(4'h8, 32'h0000_1999);
    wr(4'h0, mode_w(1, 1, 1, 0, 0, 'hABC));
    t0 = cyc;
    repeat (span - 2) @(negedge clk);
    wr(4'h8, 32'h0000_2999);
    check("R4 wrong value at zero fires", {wd_rst_o, wd_irq_o}, 2'b11);
    check("R4 wrong value timing", cyc - t0, span);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > CYCLE_LIMIT) begin
      vectors++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, CYCLE_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule